// File: doc/BRIEF.md
# Execute Stage with Branch Resolution

This block is the third stage of a five-stage, 32-bit, word-addressed in-order pipeline. Each cycle it takes one instruction from the decode/execute buffer: the 4-bit opcode, the 4-bit field that names the destination register (or the compare mode for a skip), two operand values already resolved by forwarding, the sign-extended 20-bit immediate and the address of the instruction plus one. It computes the arithmetic, logic or address result and registers it into the execute/memory buffer. The buffer carries the destination register, the write, load and store enables, a 16-bit data-memory address and the store data.

The fetch unit always predicts fall-through. This stage resolves every change of flow in the same cycle the instruction sits here. An unconditional relative jump, a register jump-and-link and a skip whose comparison holds all raise a redirect with the correct next address. They also raise a flush request for the two younger instructions already fetched. A halt instruction raises a sticky halt flag that freezes fetch. From then on the stage turns every later instruction into a bubble.

Operand convention: `opa_i` holds the register named by instruction bits [23:20] (first source, base, or jump target). `opb_i` holds the second source register, or for a store the register whose value is written to memory.

Top module: `ex_stage`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every buffer output (`xm_valid_o`, `xm_wr_en_o`, `xm_load_o`, `xm_store_o`), `redirect_o`, `flush_o` and `halt_o` are 0. A second reset clears a latched halt.
- R2: With the opcode in instruction bits [31:28]: ADD (0000) yields opa+opb, NAND (0001) yields ~(opa & opb), and ADDI (0010) yields opa+imm. Each writes `field_hi_i` as destination with `xm_wr_en_o`=1, one clock after the input.
- R3: LW (0011) and SW (0100) form opa+imm and put its low 16 bits on `xm_addr_o`. LW sets `xm_load_o` and a register write. SW sets `xm_store_o` with `xm_store_data_o`=opb and no register write. Write and store are never both set.
- R4: LEA (1001) writes pc_inc+imm. JALR (0110) writes pc_inc to the register named by `field_hi_i`.
- R5: GOTO (0101) raises `redirect_o` in its own cycle, with target pc_inc+imm, and writes no register.
- R6: JALR raises `redirect_o` in its own cycle with target opa.
- R7: SKP (1000) uses `field_hi_i` (instruction bits [27:24]) as mode. Mode 0 is taken when opa==opb. Mode 1 is taken when opa<opb as signed two's-complement. Every other mode is never taken. A taken SKP redirects to pc_inc+1 (instruction address + 2). A SKP never writes a register.
- R8: Whenever `redirect_o` is 1, both bits of `flush_o` are 1; otherwise `flush_o` is 0.
- R9: When `in_valid_i` is 0 (a bubble or squashed slot), there is no redirect, and one clock later `xm_valid_o` and all enables are 0.
- R10: A register write whose destination is register 0 has `xm_wr_en_o` forced to 0.
- R11: HALT (0111) raises `halt_o` in its own cycle, and it stays 1 until reset. While halted, later instructions cause no redirect and leave `xm_valid_o` and all enables at 0.
- R12: Opcodes 1010 to 1111 pass as valid with no enables and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Stage holds a live instruction |
| opcode_i | input | 4 | Instruction bits [31:28] |
| field_hi_i | input | 4 | Instruction bits [27:24]: destination or skip mode |
| opa_i | input | 32 | Forwarded value of register in bits [23:20] |
| opb_i | input | 32 | Forwarded second source / store value |
| imm_i | input | 32 | Sign-extended 20-bit immediate |
| pc_inc_i | input | 32 | Instruction address plus one |
| redirect_o | output | 1 | Fall-through prediction was wrong |
| redirect_pc_o | output | 32 | Correct next fetch address |
| flush_o | output | 2 | Squash the two younger instructions |
| halt_o | output | 1 | Halt reached; freeze fetch |
| xm_valid_o | output | 1 | Buffer holds a live instruction |
| xm_result_o | output | 32 | Value for writeback |
| xm_addr_o | output | 16 | Data-memory word address |
| xm_store_data_o | output | 32 | Value for a store |
| xm_dst_o | output | 4 | Destination register |
| xm_wr_en_o | output | 1 | Register write enable |
| xm_load_o | output | 1 | Memory read |
| xm_store_o | output | 1 | Memory write |

## Verification
Redirect, target and flush are combinational from the stage inputs. A wrong decision shows in the same cycle as a wrong next fetch address, or as a missing or spurious flush of two slots. Result, address and enable errors show one clock later at the execute/memory buffer. A corrupted halt latch shows at once as `halt_o` dropping, or as later instructions leaking through as valid or redirecting. The stimulus therefore checks both edges of each skip comparison, including sign-sensitive operands. It also covers a write to register 0, bubbles, and instructions arriving after a halt.

// File: rtl/ex_pkg.sv
package ex_pkg;

    localparam logic [3:0] OPC_ADD  = 4'h0;
    localparam logic [3:0] OPC_NAND = 4'h1;
    localparam logic [3:0] OPC_ADDI = 4'h2;
    localparam logic [3:0] OPC_LW   = 4'h3;
    localparam logic [3:0] OPC_SW   = 4'h4;
    localparam logic [3:0] OPC_GOTO = 4'h5;
    localparam logic [3:0] OPC_JALR = 4'h6;
    localparam logic [3:0] OPC_HALT = 4'h7;
    localparam logic [3:0] OPC_SKP  = 4'h8;
    localparam logic [3:0] OPC_LEA  = 4'h9;

    localparam logic [3:0] SKIP_EQ = 4'h0;
    localparam logic [3:0] SKIP_LT = 4'h1;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_NAND  = 2'd1,
        ALU_PASSA = 2'd2
    } alu_op_e;

    typedef struct packed {
        alu_op_e alu;
        logic    a_pc;
        logic    b_imm;
        logic    wr;
        logic    ld;
        logic    st;
        logic    halt;
        logic    jump_rel;
        logic    jump_reg;
        logic    skip;
    } ctrl_t;

endpackage

// File: rtl/ex_decode.sv
module ex_decode
    import ex_pkg::*;
(
    input  logic [3:0] opcode_i,
    output ctrl_t      ctrl_o
);

    always_comb begin
        ctrl_o = '0;
        ctrl_o.alu = ALU_ADD;
        case (opcode_i)
            OPC_ADD: begin
                ctrl_o.wr = 1'b1;
            end
            OPC_NAND: begin
                ctrl_o.alu = ALU_NAND;
                ctrl_o.wr  = 1'b1;
            end
            OPC_ADDI: begin
                ctrl_o.b_imm = 1'b1;
                ctrl_o.wr    = 1'b1;
            end
            OPC_LW: begin
                ctrl_o.b_imm = 1'b1;
                ctrl_o.wr    = 1'b1;
                ctrl_o.ld    = 1'b1;
            end
            OPC_SW: begin
                ctrl_o.b_imm = 1'b1;
                ctrl_o.st    = 1'b1;
            end
            OPC_GOTO: begin
                ctrl_o.jump_rel = 1'b1;
            end
            OPC_JALR: begin
                ctrl_o.alu      = ALU_PASSA;
                ctrl_o.a_pc     = 1'b1;
                ctrl_o.wr       = 1'b1;
                ctrl_o.jump_reg = 1'b1;
            end
            OPC_HALT: begin
                ctrl_o.halt = 1'b1;
            end
            OPC_SKP: begin
                ctrl_o.skip = 1'b1;
            end
            OPC_LEA: begin
                ctrl_o.a_pc  = 1'b1;
                ctrl_o.b_imm = 1'b1;
                ctrl_o.wr    = 1'b1;
            end
            default: begin
                ctrl_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/ex_alu.sv
module ex_alu
    import ex_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN-1:0] cmp_a_i,
    input  logic [XLEN-1:0] cmp_b_i,
    output logic [XLEN-1:0] y_o,
    output logic            eq_o,
    output logic            lt_o
);

    always_comb begin
        case (op_i)
            ALU_NAND:  y_o = ~(a_i & b_i);
            ALU_PASSA: y_o = a_i;
            default:   y_o = a_i + b_i;
        endcase
    end

    assign eq_o = (cmp_a_i == cmp_b_i);
    assign lt_o = ($signed(cmp_a_i) < $signed(cmp_b_i));

endmodule

// File: rtl/ex_branch.sv
module ex_branch
    import ex_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            live_i,
    input  logic            jump_rel_i,
    input  logic            jump_reg_i,
    input  logic            skip_i,
    input  logic [3:0]      mode_i,
    input  logic            eq_i,
    input  logic            lt_i,
    input  logic [XLEN-1:0] pc_inc_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic [XLEN-1:0] reg_tgt_i,
    output logic            redirect_o,
    output logic [XLEN-1:0] target_o
);

    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    logic cond_true;

    always_comb begin
        case (mode_i)
            SKIP_EQ: cond_true = eq_i;
            SKIP_LT: cond_true = lt_i;
            default: cond_true = 1'b0;
        endcase
    end

    always_comb begin
        redirect_o = 1'b0;
        target_o   = '0;
        if (live_i) begin
            if (jump_rel_i) begin
                redirect_o = 1'b1;
                target_o   = pc_inc_i + imm_i;
            end else if (jump_reg_i) begin
                redirect_o = 1'b1;
                target_o   = reg_tgt_i;
            end else if (skip_i && cond_true) begin
                redirect_o = 1'b1;
                target_o   = pc_inc_i + ONE;
            end
        end
    end

endmodule

// File: rtl/ex_stage.sv
module ex_stage
    import ex_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int ADDR_W      = 16,
    parameter int REG_AW      = 4,
    parameter int FLUSH_DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic [3:0]         opcode_i,
    input  logic [REG_AW-1:0]  field_hi_i,
    input  logic [XLEN-1:0]    opa_i,
    input  logic [XLEN-1:0]    opb_i,
    input  logic [XLEN-1:0]    imm_i,
    input  logic [XLEN-1:0]    pc_inc_i,
    output logic               redirect_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic [FLUSH_DEPTH-1:0] flush_o,
    output logic               halt_o,
    output logic               xm_valid_o,
    output logic [XLEN-1:0]    xm_result_o,
    output logic [ADDR_W-1:0]  xm_addr_o,
    output logic [XLEN-1:0]    xm_store_data_o,
    output logic [REG_AW-1:0]  xm_dst_o,
    output logic               xm_wr_en_o,
    output logic               xm_load_o,
    output logic               xm_store_o
);

    typedef struct packed {
        logic              valid;
        logic [XLEN-1:0]   result;
        logic [ADDR_W-1:0] addr;
        logic [XLEN-1:0]   sdata;
        logic [REG_AW-1:0] dst;
        logic              wr;
        logic              ld;
        logic              st;
        logic              halted;
    } xm_state_t;

    xm_state_t st_d, st_q;

    ctrl_t           ctrl;
    logic            live;
    logic            halt_now;
    logic [XLEN-1:0] alu_a, alu_b, alu_y;
    logic            cmp_eq, cmp_lt;
    logic            redirect;
    logic [XLEN-1:0] target;

    ex_decode u_decode (
        .opcode_i (opcode_i),
        .ctrl_o   (ctrl)
    );

    assign live     = in_valid_i && !st_q.halted;
    assign halt_now = st_q.halted || (in_valid_i && ctrl.halt);

    assign alu_a = ctrl.a_pc  ? pc_inc_i : opa_i;
    assign alu_b = ctrl.b_imm ? imm_i    : opb_i;

    ex_alu #(.XLEN(XLEN)) u_alu (
        .op_i    (ctrl.alu),
        .a_i     (alu_a),
        .b_i     (alu_b),
        .cmp_a_i (opa_i),
        .cmp_b_i (opb_i),
        .y_o     (alu_y),
        .eq_o    (cmp_eq),
        .lt_o    (cmp_lt)
    );

    ex_branch #(.XLEN(XLEN)) u_branch (
        .live_i     (live),
        .jump_rel_i (ctrl.jump_rel),
        .jump_reg_i (ctrl.jump_reg),
        .skip_i     (ctrl.skip),
        .mode_i     (field_hi_i[3:0]),
        .eq_i       (cmp_eq),
        .lt_i       (cmp_lt),
        .pc_inc_i   (pc_inc_i),
        .imm_i      (imm_i),
        .reg_tgt_i  (opa_i),
        .redirect_o (redirect),
        .target_o   (target)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = live;
        st_d.wr     = live && ctrl.wr && (field_hi_i != '0);
        st_d.ld     = live && ctrl.ld;
        st_d.st     = live && ctrl.st;
        st_d.dst    = live ? field_hi_i : '0;
        st_d.result = live ? alu_y : '0;
        st_d.addr   = live ? alu_y[ADDR_W-1:0] : '0;
        st_d.sdata  = live ? opb_i : '0;
        st_d.halted = halt_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar k = 0; k < FLUSH_DEPTH; k++) begin : g_flush
            assign flush_o[k] = redirect;
        end
    endgenerate

    assign redirect_o      = redirect;
    assign redirect_pc_o   = target;
    assign halt_o          = halt_now;
    assign xm_valid_o      = st_q.valid;
    assign xm_result_o     = st_q.result;
    assign xm_addr_o       = st_q.addr;
    assign xm_store_data_o = st_q.sdata;
    assign xm_dst_o        = st_q.dst;
    assign xm_wr_en_o      = st_q.wr;
    assign xm_load_o       = st_q.ld;
    assign xm_store_o      = st_q.st;

endmodule

// File: rtl/ex_stage_chk.sv
module ex_stage_chk #(
    parameter int XLEN        = 32,
    parameter int REG_AW      = 4,
    parameter int FLUSH_DEPTH = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid_i,
    input logic [3:0]             opcode_i,
    input logic [XLEN-1:0]        opa_i,
    input logic [XLEN-1:0]        imm_i,
    input logic [XLEN-1:0]        pc_inc_i,
    input logic                   redirect_o,
    input logic [XLEN-1:0]        redirect_pc_o,
    input logic [FLUSH_DEPTH-1:0] flush_o,
    input logic                   halt_o,
    input logic                   xm_valid_o,
    input logic [REG_AW-1:0]      xm_dst_o,
    input logic                   xm_wr_en_o,
    input logic                   xm_store_o
);

    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    assert_wr_store_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(xm_wr_en_o && xm_store_o));

    assert_goto_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && opcode_i == 4'h5 && !halt_o)
        |-> (redirect_o && redirect_pc_o == pc_inc_i + imm_i));

    assert_jalr_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && opcode_i == 4'h6 && !halt_o)
        |-> (redirect_o && redirect_pc_o == opa_i));

    assert_skip_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && opcode_i == 4'h8) |-> (redirect_pc_o == pc_inc_i + ONE));

    assert_flush_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (&flush_o));

    assert_bubble_no_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |-> !redirect_o);

    assert_bubble_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !xm_valid_o);

    assert_no_zero_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xm_wr_en_o |-> (xm_dst_o != '0));

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    assert_halt_no_redirect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !redirect_o);

endmodule

bind ex_stage ex_stage_chk #(
    .XLEN        (XLEN),
    .REG_AW      (REG_AW),
    .FLUSH_DEPTH (FLUSH_DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid_i    (in_valid_i),
    .opcode_i      (opcode_i),
    .opa_i         (opa_i),
    .imm_i         (imm_i),
    .pc_inc_i      (pc_inc_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .flush_o       (flush_o),
    .halt_o        (halt_o),
    .xm_valid_o    (xm_valid_o),
    .xm_dst_o      (xm_dst_o),
    .xm_wr_en_o    (xm_wr_en_o),
    .xm_store_o    (xm_store_o)
);

// File: tb/ex_stage_tb.sv
module ex_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [3:0]  opcode_i = '0;
    logic [3:0]  field_hi_i = '0;
    logic [31:0] opa_i = '0, opb_i = '0, imm_i = '0, pc_inc_i = '0;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;
    logic [1:0]  flush_o;
    logic        halt_o;
    logic        xm_valid_o;
    logic [31:0] xm_result_o;
    logic [15:0] xm_addr_o;
    logic [31:0] xm_store_data_o;
    logic [3:0]  xm_dst_o;
    logic        xm_wr_en_o, xm_load_o, xm_store_o;

    ex_stage dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .opcode_i(opcode_i),
        .field_hi_i(field_hi_i), .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i),
        .pc_inc_i(pc_inc_i), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .flush_o(flush_o), .halt_o(halt_o), .xm_valid_o(xm_valid_o),
        .xm_result_o(xm_result_o), .xm_addr_o(xm_addr_o),
        .xm_store_data_o(xm_store_data_o), .xm_dst_o(xm_dst_o),
        .xm_wr_en_o(xm_wr_en_o), .xm_load_o(xm_load_o), .xm_store_o(xm_store_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        string       tag;
        logic        valid, wr, ld, st;
        logic [3:0]  dst;
        logic [31:0] result;
        logic [15:0] addr;
        logic [31:0] sdata;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   mon_en  = 0;
    bit   tb_halted = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic v, input logic [3:0] op,
                         input logic [3:0] fh, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] imm, input logic [31:0] pc);
        exp_t        e;
        logic        live, hnow, red;
        logic [31:0] tgt, sum;
        @(negedge clk);
        in_valid_i = v; opcode_i = op; field_hi_i = fh;
        opa_i = a; opb_i = b; imm_i = imm; pc_inc_i = pc;
        live = v && !tb_halted;
        hnow = tb_halted || (v && op == 4'h7);
        red = 1'b0; tgt = '0;
        if (live) begin
            case (op)
                4'h5: begin red = 1'b1; tgt = pc + imm; end
                4'h6: begin red = 1'b1; tgt = a; end
                4'h8: if ((fh == 4'h0 && a == b) ||
                          (fh == 4'h1 && $signed(a) < $signed(b))) begin
                          red = 1'b1; tgt = pc + 32'd1;
                      end
                default: ;
            endcase
        end
        sum = a + imm;
        e.tag   = tag;
        e.valid = live;
        e.wr    = live && (op inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h6, 4'h9}) && fh != 4'h0;
        e.ld    = live && op == 4'h3;
        e.st    = live && op == 4'h4;
        e.dst   = fh;
        case (op)
            4'h0:    e.result = a + b;
            4'h1:    e.result = ~(a & b);
            4'h6:    e.result = pc;
            4'h9:    e.result = pc + imm;
            default: e.result = sum;
        endcase
        e.addr  = sum[15:0];
        e.sdata = b;
        #1;
        chk(redirect_o == red, {tag, " redirect"}, {31'd0, redirect_o}, {31'd0, red});
        if (red) chk(redirect_pc_o == tgt, {tag, " target"}, redirect_pc_o, tgt);
        chk(flush_o == {red, red}, {tag, " flush R8"}, {30'd0, flush_o}, {30'd0, red, red});
        chk(halt_o == hnow, {tag, " halt"}, {31'd0, halt_o}, {31'd0, hnow});
        q.push_back(e);
        tb_halted = hnow;
    endtask

    task automatic idle();
        drive("bubble R9", 1'b0, 4'h0, 4'h3, 32'd1, 32'd2, 32'd0, 32'd0);
    endtask

    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (mon_en && q.size() > 0) begin
                e = q.pop_front();
                chk(xm_valid_o == e.valid, {e.tag, " valid"}, {31'd0, xm_valid_o}, {31'd0, e.valid});
                chk(xm_wr_en_o == e.wr, {e.tag, " wr_en"}, {31'd0, xm_wr_en_o}, {31'd0, e.wr});
                chk(xm_load_o == e.ld, {e.tag, " load"}, {31'd0, xm_load_o}, {31'd0, e.ld});
                chk(xm_store_o == e.st, {e.tag, " store"}, {31'd0, xm_store_o}, {31'd0, e.st});
                if (e.wr) begin
                    chk(xm_result_o == e.result, {e.tag, " result"}, xm_result_o, e.result);
                    chk(xm_dst_o == e.dst, {e.tag, " dst"}, {28'd0, xm_dst_o}, {28'd0, e.dst});
                end
                if (e.ld || e.st)
                    chk(xm_addr_o == e.addr, {e.tag, " addr"}, {16'd0, xm_addr_o}, {16'd0, e.addr});
                if (e.st)
                    chk(xm_store_data_o == e.sdata, {e.tag, " sdata"}, xm_store_data_o, e.sdata);
            end
        end
    end

    task automatic do_reset();
        mon_en = 0;
        @(negedge clk);
        rst_n = 1'b0; in_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(!xm_valid_o && !xm_wr_en_o && !xm_load_o && !xm_store_o, "R1 buffer in reset",
            {28'd0, xm_valid_o, xm_wr_en_o, xm_load_o, xm_store_o}, 32'd0);
        chk(!redirect_o && flush_o == 2'b00 && !halt_o, "R1 flow in reset",
            {29'd0, redirect_o, halt_o, |flush_o}, 32'd0);
        q.delete();
        tb_halted = 0;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(!xm_valid_o && !halt_o, "R1 after reset", {30'd0, xm_valid_o, halt_o}, 32'd0);
        mon_en = 1;
    endtask

    initial begin
        do_reset();
        drive("R2 add", 1, 4'h0, 4'h3, 32'd5, 32'd7, 32'd0, 32'd20);
        drive("R2 nand", 1, 4'h1, 4'h4, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'd0, 32'd21);
        drive("R2 addi", 1, 4'h2, 4'h5, 32'd10, 32'd0, 32'hFFFF_FFFD, 32'd22);
        drive("R3 lw", 1, 4'h3, 4'h4, 32'h0001_FFF0, 32'd0, 32'h20, 32'd23);
        drive("R3 sw", 1, 4'h4, 4'h6, 32'h100, 32'hCAFE_0001, 32'hFFFF_FFFF, 32'd24);
        drive("R4 lea", 1, 4'h9, 4'h7, 32'd0, 32'd0, 32'hFFFF_FFCE, 32'd100);
        drive("R4 R6 jalr", 1, 4'h6, 4'hF, 32'h200, 32'd0, 32'd0, 32'h40);
        drive("R5 goto", 1, 4'h5, 4'h0, 32'd0, 32'd0, 32'd5, 32'd10);
        drive("R5 goto back", 1, 4'h5, 4'h0, 32'd0, 32'd0, 32'hFFFF_FFF0, 32'd40);
        drive("R7 skpe taken", 1, 4'h8, 4'h0, 32'd9, 32'd9, 32'd0, 32'd50);
        drive("R7 skpe not", 1, 4'h8, 4'h0, 32'd9, 32'd8, 32'd0, 32'd51);
        drive("R7 skplt signed taken", 1, 4'h8, 4'h1, 32'hFFFF_FFFF, 32'd1, 32'd0, 32'd52);
        drive("R7 skplt signed not", 1, 4'h8, 4'h1, 32'd1, 32'hFFFF_FFFF, 32'd0, 32'd53);
        drive("R7 skplt equal not", 1, 4'h8, 4'h1, 32'd4, 32'd4, 32'd0, 32'd54);
        drive("R7 skip mode2 never", 1, 4'h8, 4'h2, 32'd3, 32'd3, 32'd0, 32'd55);
        drive("R10 add to r0", 1, 4'h0, 4'h0, 32'd1, 32'd1, 32'd0, 32'd56);
        drive("R9 squashed goto", 0, 4'h5, 4'h0, 32'd0, 32'd0, 32'd5, 32'd57);
        drive("R12 undefined", 1, 4'hC, 4'h3, 32'd1, 32'd2, 32'd3, 32'd58);
        idle();
        drive("R11 halt", 1, 4'h7, 4'h0, 32'd0, 32'd0, 32'd0, 32'd60);
        drive("R11 jalr after halt", 1, 4'h6, 4'h2, 32'h300, 32'd0, 32'd0, 32'd61);
        drive("R11 add after halt", 1, 4'h0, 4'h2, 32'd1, 32'd1, 32'd0, 32'd62);
        idle();
        @(negedge clk);
        do_reset();
        drive("R1 halt cleared goto", 1, 4'h5, 4'h0, 32'd0, 32'd0, 32'd2, 32'd70);
        idle();
        repeat (3) @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule